// File: doc/BRIEF.md
# Banked Internal Data RAM with Stack Pointer

This block holds the 128-byte internal data RAM of a small 8-bit controller together with the address logic in front of it. Each command names a byte in one of four ways. A register number is taken inside the active group of eight working registers. A direct address reaches any RAM byte. An indirect access uses R0 or R1 of the active group as a pointer. A bit address selects one bit inside the bit-addressable window. The same array also holds an upward-growing stack, which the block's own 8-bit stack pointer drives.

Every command completes in a single clock. Read results and status flags appear as registered outputs on the following cycle. Byte addresses of 80h and above belong to special-function space, which is not stored here. Accesses there are flagged, read as zero and leave the RAM untouched. A push or pop whose stack slot falls at 80h or above is reported as a stack error and does not touch the RAM.

Top module: `iram_bank_stack`

## Requirements
- R1: After reset the stack pointer reads 07h, register group 0 is active, the read data is 00h, both flags are low and every RAM byte holds 00h.
- R2: Command code 7 loads the active group from `bank_i`. In register mode (mode 0) the register number `addr_i[2:0]` addresses byte group*8 + number.
- R3: In direct mode (mode 1) an address below 80h reaches that byte, including registers of an inactive group.
- R4: In indirect mode (mode 2) the pointer is R0 (`addr_i[0]`=0) or R1 (`addr_i[0]`=1) of the active group. A pointer of 80h or above raises `sfr_hit_o`, reads 00h and writes nothing.
- R5: In bit mode (mode 3) a bit address b below 80h selects bit b[2:0] of byte 20h + b[6:3]. A read returns that bit in `rdata_o[0]`, with the upper bits zero. A write stores `wdata_i[0]`.
- R6: Bit-set (code 3) and bit-clear (code 4) always use bit addressing. They change only the addressed bit and leave the other seven bits of that byte unchanged.
- R7: A direct or bit address of 80h or above raises `sfr_hit_o` for one cycle. A read of such an address returns 00h, and a write to it leaves every RAM byte unchanged.
- R8: A push (code 5) first increments the stack pointer and then writes `wdata_i` at the new value.
- R9: A pop (code 6) first reads the byte at the stack pointer into `rdata_o` and then decrements the pointer.
- R10: The stack pointer wraps modulo 256. A push or pop whose slot is 80h or above raises `stk_err_o` for one cycle, writes nothing, returns 00h on a pop, and still moves the pointer.
- R11: `rdata_o` changes only after a read (code 1) or a pop. Idle (code 0), writes and group loads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Command: 0 idle, 1 read, 2 write, 3 bit-set, 4 bit-clear, 5 push, 6 pop, 7 group load |
| mode_i | input | 2 | Addressing: 0 register, 1 direct, 2 indirect, 3 bit |
| addr_i | input | 8 | Register number, direct address, pointer select or bit address |
| bank_i | input | 2 | Group number taken by a group load |
| wdata_i | input | 8 | Write and push data |
| rdata_o | output | 8 | Registered read or pop result |
| sp_o | output | 8 | Current stack pointer |
| sfr_hit_o | output | 1 | One-cycle flag: the access fell in special-function space |
| stk_err_o | output | 1 | One-cycle flag: push or pop slot outside RAM |

## Verification
The bench writes the same register number in two groups and then reads both bytes back by direct address. A design that ignored the group select, or got the group stride wrong, would alias the two writes. Bit-set and bit-clear are applied to bytes that already hold other ones. A design without read-modify-write would wipe out the neighbouring bits, and a wrong index shift would land in the wrong byte of the window. The stack is pushed across the 7Fh/80h boundary and around from FFh to 00h. A design that stored above 7Fh would corrupt low RAM through the dropped top bit, and a design that saturated instead of wrapping would leave the pointer stuck. Writes into special-function space are followed by a read of the byte that aliases them in the low half, so that a design which fails to block those writes is exposed.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DW          = 8;
  localparam int RAM_WORDS   = 128;
  localparam int AW          = $clog2(RAM_WORDS);
  localparam int REG_BITS    = 3;
  localparam int GRP_BITS    = 2;
  localparam int BIT_BASE    = 32;
  localparam logic [DW-1:0] SP_RESET = 8'h07;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0, OP_READ = 3'd1, OP_WRITE = 3'd2, OP_BSET = 3'd3,
    OP_BCLR = 3'd4, OP_PUSH = 3'd5, OP_POP   = 3'd6, OP_GRP  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    AM_REG = 2'd0, AM_DIR = 2'd1, AM_IND = 2'd2, AM_BIT = 2'd3
  } amode_e;
endpackage

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int WORDS = RAM_WORDS,
  parameter int W     = DW,
  localparam int A    = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [A-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [A-1:0] raddr_a,
  output logic [W-1:0] rdata_a,
  input  logic [A-1:0] raddr_p,
  output logic [W-1:0] rdata_p
);
  logic [W-1:0] mem_q [WORDS];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic hit_en;
    assign hit_en = we && (waddr == A'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[gi] <= '0;
      else if (hit_en) mem_q[gi] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_p = mem_q[raddr_p];

  // R3: a write is visible at its address on the next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
(
  input  logic [1:0]    mode_i,
  input  logic [7:0]    addr_i,
  input  logic [GRP_BITS-1:0] grp_i,
  input  logic [DW-1:0] ptr_val_i,
  output logic [AW-1:0] ptr_addr_o,
  output logic [AW-1:0] byte_addr_o,
  output logic [2:0]    bit_idx_o,
  output logic          is_bit_o,
  output logic          sfr_hit_o
);
  localparam int PAD = AW - GRP_BITS - REG_BITS;

  always_comb begin
    ptr_addr_o  = {PAD'(0), grp_i, (REG_BITS-1)'(0), addr_i[0]};
    bit_idx_o   = addr_i[2:0];
    is_bit_o    = 1'b0;
    sfr_hit_o   = 1'b0;
    byte_addr_o = '0;
    unique case (amode_e'(mode_i))
      AM_REG: byte_addr_o = {PAD'(0), grp_i, addr_i[REG_BITS-1:0]};
      AM_DIR: begin
        byte_addr_o = addr_i[AW-1:0];
        sfr_hit_o   = addr_i[7];
      end
      AM_IND: begin
        byte_addr_o = ptr_val_i[AW-1:0];
        sfr_hit_o   = ptr_val_i[7];
      end
      AM_BIT: begin
        byte_addr_o = AW'(BIT_BASE) + AW'(addr_i[6:3]);
        is_bit_o    = 1'b1;
        sfr_hit_o   = addr_i[7];
      end
      default: ;
    endcase
  end

  // R5: a mapped bit always lands inside the 20h..2Fh window
  always_comb begin
    if (is_bit_o && !sfr_hit_o)
      p_bit_window_r5: assert (byte_addr_o >= AW'(BIT_BASE) && byte_addr_o < AW'(BIT_BASE + 16));
  end
endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr
  import iram_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] sp_inc_o
);
  logic [DW-1:0] sp_q, sp_d;
  logic          sp_en;

  assign sp_inc_o = sp_q + DW'(1);

  always_comb begin
    sp_en = push_i || pop_i;
    sp_d  = push_i ? sp_inc_o : (sp_q - DW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RESET;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp_o = sp_q;

  // R8: push moves the pointer up by one, modulo 256
  p_push_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (sp_q == $past(sp_q) + DW'(1)));
  // R9: pop moves the pointer down by one, modulo 256
  p_pop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (sp_q == $past(sp_q) - DW'(1)));
  // R10: without stack traffic the pointer holds
  p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(sp_q));
endmodule

// File: rtl/iram_bank_stack.sv
module iram_bank_stack
  import iram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] addr_i,
  input  logic [1:0] bank_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] sp_o,
  output logic       sfr_hit_o,
  output logic       stk_err_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  op_e              op;
  logic [1:0]       mode_eff;
  logic [GRP_BITS-1:0] grp_q, grp_d;
  logic [DW-1:0]    sp, sp_inc, rd_a, rd_p, mod_byte, wr_data;
  logic [AW-1:0]    ptr_addr, byte_addr, rd_addr;
  logic [2:0]       bit_idx;
  logic             is_bit, map_sfr, is_push, is_pop, mem_op;
  logic             push_err, pop_err, we, bit_val;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             rdata_en, sfr_q, sfr_d, err_q, err_d;

  assign op       = op_e'(op_i);
  assign is_push  = (op == OP_PUSH);
  assign is_pop   = (op == OP_POP);
  assign mode_eff = (op == OP_BSET || op == OP_BCLR) ? 2'(AM_BIT) : mode_i;

  iram_addr_map u_map (
    .mode_i(mode_eff), .addr_i(addr_i), .grp_i(grp_q), .ptr_val_i(rd_p),
    .ptr_addr_o(ptr_addr), .byte_addr_o(byte_addr), .bit_idx_o(bit_idx),
    .is_bit_o(is_bit), .sfr_hit_o(map_sfr)
  );

  iram_stack_ptr u_sp (
    .clk(clk), .rst_n(rst_sync_q), .push_i(is_push), .pop_i(is_pop),
    .sp_o(sp), .sp_inc_o(sp_inc)
  );

  iram_store u_mem (
    .clk(clk), .rst_n(rst_sync_q), .we(we), .waddr(rd_addr), .wdata(wr_data),
    .raddr_a(rd_addr), .rdata_a(rd_a), .raddr_p(ptr_addr), .rdata_p(rd_p)
  );

  // next-state logic
  always_comb begin
    mem_op   = (op == OP_READ) || (op == OP_WRITE) || (op == OP_BSET) || (op == OP_BCLR);
    push_err = sp_inc[7];
    pop_err  = sp[7];
    rd_addr  = is_pop ? sp[AW-1:0] : (is_push ? sp_inc[AW-1:0] : byte_addr);

    bit_val  = (op == OP_BSET) ? 1'b1 : ((op == OP_BCLR) ? 1'b0 : wdata_i[0]);
    mod_byte = rd_a;
    mod_byte[bit_idx] = bit_val;
    wr_data  = (!is_push && is_bit) ? mod_byte : wdata_i;

    we = 1'b0;
    if (is_push)                                          we = !push_err;
    else if (op == OP_WRITE || op == OP_BSET || op == OP_BCLR) we = !map_sfr;

    rdata_en = (op == OP_READ) || is_pop;
    rdata_d  = '0;
    if (op == OP_READ && !map_sfr)
      rdata_d = is_bit ? {7'd0, rd_a[bit_idx]} : rd_a;
    else if (is_pop && !pop_err)
      rdata_d = rd_a;

    sfr_d = mem_op && map_sfr;
    err_d = (is_push && push_err) || (is_pop && pop_err);
    grp_d = bank_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rdata_q <= '0;
      sfr_q   <= 1'b0;
      err_q   <= 1'b0;
      grp_q   <= '0;
    end else begin
      sfr_q <= sfr_d;
      err_q <= err_d;
      if (rdata_en)      rdata_q <= rdata_d;
      if (op == OP_GRP)  grp_q   <= grp_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign sp_o      = sp;
  assign sfr_hit_o = sfr_q;
  assign stk_err_o = err_q;

  // R7: a read in special-function space returns zero
  p_sfr_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (op == OP_READ && map_sfr) |=> (rdata_o == 8'h00 && sfr_hit_o));
  // R10: a stack error only follows push or pop
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!is_push && !is_pop) |=> !stk_err_o);
  // R11: read data holds unless a read or pop was issued
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (op != OP_READ && !is_pop) |=> $stable(rdata_o));
  // R4: the indirect pointer comes from R0/R1 of the active group
  p_ptr_in_group_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    1'b1 |-> (ptr_addr[AW-1:REG_BITS] == {2'b00, grp_q} && ptr_addr[2:1] == 2'b00));
endmodule

// File: tb/iram_bank_stack_tb.sv
module iram_bank_stack_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_i;
  logic [1:0] mode_i;
  logic [7:0] addr_i, wdata_i;
  logic [1:0] bank_i;
  logic [7:0] rdata_o, sp_o;
  logic       sfr_hit_o, stk_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m [128];
  int msp, mgrp;
  logic [7:0] erd;

  iram_bank_stack u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_i(mode_i), .addr_i(addr_i),
    .bank_i(bank_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .sp_o(sp_o),
    .sfr_hit_o(sfr_hit_o), .stk_err_o(stk_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [1:0] md, input logic [7:0] a,
                      input logic [7:0] wd, input logic [1:0] bk, input string tag);
    int ba, bi, emd;
    bit hit, isb, esfr, eerr;
    op_i = op; mode_i = md; addr_i = a; wdata_i = wd; bank_i = bk;
    emd = (op == 3 || op == 4) ? 3 : md;
    hit = 0; isb = 0; bi = a[2:0]; ba = 0;
    case (emd)
      0: ba = mgrp * 8 + a[2:0];
      1: begin ba = a[6:0]; hit = a[7]; end
      2: begin ba = m[mgrp * 8 + a[0]]; hit = (ba >= 128); ba = ba % 128; end
      default: begin ba = 32 + a[6:3]; hit = a[7]; isb = 1; end
    endcase
    esfr = 0; eerr = 0;
    case (op)
      1: begin esfr = hit; erd = hit ? 8'h00 : (isb ? {7'd0, m[ba][bi]} : m[ba]); end
      2: begin esfr = hit; if (!hit) begin if (isb) m[ba][bi] = wd[0]; else m[ba] = wd; end end
      3: begin esfr = hit; if (!hit) m[ba][bi] = 1'b1; end
      4: begin esfr = hit; if (!hit) m[ba][bi] = 1'b0; end
      5: begin msp = (msp + 1) % 256; if (msp >= 128) eerr = 1; else m[msp] = wd; end
      6: begin
        if (msp >= 128) begin eerr = 1; erd = 8'h00; end else erd = m[msp];
        msp = (msp + 255) % 256;
      end
      7: mgrp = bk;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    check(tag, "rdata", rdata_o, erd);
    check(tag, "sp", sp_o, msp);
    check(tag, "sfr_hit", sfr_hit_o, esfr);
    check(tag, "stk_err", stk_err_o, eerr);
  endtask

  task automatic rd(input logic [1:0] md, input logic [7:0] a, input string tag);
    step(3'd1, md, a, 8'h00, 2'd0, tag);
  endtask

  task automatic wr(input logic [1:0] md, input logic [7:0] a, input logic [7:0] d, input string tag);
    step(3'd2, md, a, d, 2'd0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    msp = 7; mgrp = 0; erd = 8'h00;
    op_i = 3'd0; mode_i = 2'd0; addr_i = 8'h00; wdata_i = 8'h00; bank_i = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    check("R1", "sp", sp_o, 8'h07);
    check("R1", "rdata", rdata_o, 8'h00);
    check("R1", "sfr_hit", sfr_hit_o, 0);
    check("R1", "stk_err", stk_err_o, 0);
    rd(2'd1, 8'h33, "R1");
    rd(2'd0, 8'h05, "R1");  // group 0 active: R5 is byte 05h

    // R2: register window per group
    wr(2'd0, 8'h03, 8'hA5, "R2");
    step(3'd7, 2'd0, 8'h00, 8'h00, 2'd2, "R2");
    wr(2'd0, 8'h03, 8'h3C, "R2");
    rd(2'd0, 8'h03, "R2");
    step(3'd7, 2'd0, 8'h00, 8'h00, 2'd3, "R2");
    wr(2'd0, 8'h07, 8'h77, "R2");
    rd(2'd1, 8'h1F, "R2");
    step(3'd7, 2'd0, 8'h00, 8'h00, 2'd2, "R2");

    // R3: direct reach, including other groups
    rd(2'd1, 8'h13, "R3");
    rd(2'd1, 8'h03, "R3");
    wr(2'd1, 8'h7F, 8'h5E, "R3");
    rd(2'd1, 8'h7F, "R3");
    wr(2'd1, 8'h0B, 8'hC4, "R3");
    rd(2'd0, 8'h03, "R3");

    // R4: indirect through R0/R1 of group 2
    wr(2'd0, 8'h01, 8'h40, "R4");
    wr(2'd2, 8'h01, 8'h99, "R4");
    rd(2'd1, 8'h40, "R4");
    rd(2'd2, 8'h01, "R4");
    wr(2'd0, 8'h00, 8'h90, "R4");
    rd(2'd2, 8'h00, "R4");
    wr(2'd2, 8'h00, 8'h12, "R4");
    rd(2'd1, 8'h10, "R4");

    // R5 / R6: bit window
    wr(2'd1, 8'h21, 8'h81, "R6");
    step(3'd3, 2'd0, 8'h0B, 8'h00, 2'd0, "R6");
    rd(2'd1, 8'h21, "R6");
    rd(2'd3, 8'h0B, "R5");
    rd(2'd3, 8'h0A, "R5");
    step(3'd4, 2'd1, 8'h08, 8'h00, 2'd0, "R6");
    rd(2'd1, 8'h21, "R6");
    step(3'd3, 2'd0, 8'h7F, 8'h00, 2'd0, "R5");
    rd(2'd1, 8'h2F, "R5");
    wr(2'd3, 8'h00, 8'hFF, "R5");
    wr(2'd3, 8'h01, 8'hFE, "R5");
    rd(2'd1, 8'h20, "R5");

    // R7: special-function space
    wr(2'd1, 8'hA0, 8'h55, "R7");
    rd(2'd1, 8'h20, "R7");
    rd(2'd1, 8'h90, "R7");
    step(3'd3, 2'd0, 8'h88, 8'h00, 2'd0, "R7");
    rd(2'd1, 8'h21, "R7");
    rd(2'd3, 8'h8B, "R7");

    // R8 / R9: push then pop
    step(3'd5, 2'd0, 8'h00, 8'h11, 2'd0, "R8");
    step(3'd5, 2'd0, 8'h00, 8'h22, 2'd0, "R8");
    rd(2'd1, 8'h09, "R8");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R9");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R9");
    rd(2'd1, 8'h08, "R9");

    // R11: output holds across non-reads
    step(3'd0, 2'd0, 8'h00, 8'h00, 2'd0, "R11");
    wr(2'd1, 8'h50, 8'hEE, "R11");
    step(3'd7, 2'd0, 8'h00, 8'h00, 2'd1, "R11");
    step(3'd3, 2'd0, 8'h10, 8'h00, 2'd0, "R11");

    // R10: cross 7Fh/80h and wrap through FFh
    for (int i = 0; i < 121; i++) step(3'd5, 2'd0, 8'h00, 8'(i + 1), 2'd0, "R10");
    rd(2'd1, 8'h00, "R10");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R10");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R10");
    for (int i = 0; i < 130; i++) step(3'd5, 2'd0, 8'h00, 8'hD0, 2'd0, "R10");
    rd(2'd1, 8'h01, "R10");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R10");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R10");
    step(3'd6, 2'd0, 8'h00, 8'h00, 2'd0, "R10");
    step(3'd0, 2'd0, 8'h00, 8'h00, 2'd0, "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule